// File: doc/BRIEF.md
# SPI Slave Receiver with FIFO Timeout

This block is the receive half of an SPI slave. It runs entirely on the system clock and oversamples the serial clock, the frame select and the data line. It builds 16-bit words and stores them in an 8-entry FIFO, which a host drains one word at a time through a pop strobe. The serial bus uses clock polarity 1 and phase 0. The clock idles high, and each bit is taken on the falling edge of the serial clock. Every low phase of the frame select carries exactly one word.

Three interrupt sources are reported: a FIFO fill level, a receive timeout and an overrun. The timeout serves words that arrive too slowly to reach the fill level. It starts counting bit periods when the first word lands in an empty FIFO, and it fires after 32 bit periods unless the host has emptied the FIFO first. A bit period is set by a system-clock prescaler, so the count keeps running while the bus is idle. Each source has a raw bit, an enable bit, a masked bit and a write-one-to-clear strobe. A single interrupt line carries the OR of the masked bits.

Top module: `spi_slave_rx`

## Requirements
- R1: While cs_n_i is low, each falling transition of sclk_i takes one bit from mosi_i, most significant bit first. Sixteen bits make one word. The system clock must run at least 6 times faster than sclk_i. mosi_i must be stable for at least 3 system clocks around the falling transition.
- R2: One word is taken per low phase of cs_n_i. Falling edges after the sixteenth bit are ignored until cs_n_i goes high. If cs_n_i goes high before sixteen bits arrive, the partial word is discarded.
- R3: A word is written into the FIFO (depth 8) on the fourth rising clk edge after the sclk_i fall that carries its sixteenth bit. rd_data_o shows the oldest word. A rd_en_i high at a rising edge removes that word. rd_en_i has no effect when the FIFO is empty. rx_level_o gives the word count and rx_empty_o is high when the count is 0.
- R4: A word that arrives while the FIFO holds 8 words, with no pop at the same edge, is dropped. It sets the sticky overrun raw bit (irq_raw_o bit 2). That bit is cleared by a high irq_clr_i bit 2. A new overrun at the same edge as the clear wins.
- R5: The half-full raw bit (irq_raw_o bit 0) is high whenever 4 or more words are held. It follows the level, and irq_clr_i bit 0 has no effect on it.
- R6: The timeout raw bit (irq_raw_o bit 1) becomes 1 at the rising edge exactly 32*(bit_div_i+1) clocks after the edge at which a word entered an empty FIFO, provided the FIFO has not become empty in between.
- R7: The pop that empties the FIFO clears the timeout raw bit at that same edge and stops the count. No timeout follows until a word enters the empty FIFO again.
- R8: A high irq_clr_i bit 1 clears a latched timeout. The timeout does not fire again until the FIFO has gone empty and received a word. A timeout that fires at the same edge as the clear stays set.
- R9: irq_masked_o is irq_raw_o ANDed with irq_mask_i, bit by bit. irq_o is high when any masked bit is high.
- R10: After reset the FIFO is empty, rx_level_o is 0, and all raw bits, masked bits and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master, idles high |
| cs_n_i | input | 1 | Frame select, active low, one word per low phase |
| mosi_i | input | 1 | Serial data from the master |
| bit_div_i | input | 8 | Clocks per timeout bit period, minus one |
| rd_en_i | input | 1 | Pop the oldest word |
| rd_data_o | output | 16 | Oldest word in the FIFO |
| rx_level_o | output | 4 | Number of words held |
| rx_empty_o | output | 1 | FIFO holds no word |
| irq_mask_i | input | 3 | Enable per source: bit0 half-full, bit1 timeout, bit2 overrun |
| irq_clr_i | input | 3 | Write-one-to-clear strobe per source, same bit order |
| irq_raw_o | output | 3 | Raw status per source |
| irq_masked_o | output | 3 | Raw status ANDed with the enables |
| irq_o | output | 1 | OR of the masked status |

## Verification
Two pairs of events can fall on the same clock edge and have a defined winner. The first pair is timeout expiry and a software clear of the timeout. The bench records the edge at which a word entered the empty FIFO and pulses the timeout clear so that it is high at exactly the expiry edge. The raw bit must stay set, and a later clear must leave it low with no further firing. The second pair is overrun detection and its clear. The bench fills the FIFO, sends a ninth word, and raises the overrun clear at the edge where that word would be written. The sticky bit must be set, and the level must remain at eight.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    // interrupt source positions in the raw / mask / clear vectors
    localparam int IRQ_N    = 3;
    localparam int IRQ_HALF = 0;
    localparam int IRQ_TMO  = 1;
    localparam int IRQ_OVR  = 2;
endpackage

// File: rtl/spi_rx_front.sv
module spi_rx_front #(
    parameter int WORD_W = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    output logic              push_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [SYNC_N-1:0] sck;
        logic [SYNC_N-1:0] sel;
        logic [SYNC_N-1:0] dat;
        logic              sck_prev;
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              push;
        logic [WORD_W-1:0] word;
    } front_t;

    localparam front_t FRONT_RST = '{
        sck: '1, sel: '1, dat: '0, sck_prev: 1'b1,
        shift: '0, cnt: '0, done: 1'b0, push: 1'b0, word: '0
    };

    front_t st_q, st_d;
    logic   sck_s, sel_s, dat_s, fall;

    always_comb begin
        // oldest stage of each synchroniser is the usable sample
        sck_s = st_q.sck[SYNC_N-1];
        sel_s = st_q.sel[SYNC_N-1];
        dat_s = st_q.dat[SYNC_N-1];
        fall  = st_q.sck_prev & ~sck_s;

        st_d          = st_q;
        st_d.sck      = {st_q.sck[SYNC_N-2:0], sclk_i};
        st_d.sel      = {st_q.sel[SYNC_N-2:0], cs_n_i};
        st_d.dat      = {st_q.dat[SYNC_N-2:0], mosi_i};
        st_d.sck_prev = sck_s;
        st_d.push     = 1'b0;

        if (sel_s) begin
            // frame boundary: drop partial word, re-arm for the next one
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (fall && !st_q.done) begin
            st_d.shift = {st_q.shift[WORD_W-2:0], dat_s};
            if (st_q.cnt == LAST_BIT) begin
                st_d.push = 1'b1;
                st_d.word = {st_q.shift[WORD_W-2:0], dat_s};
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FRONT_RST;
        else        st_q <= st_d;
    end

    assign push_o = st_q.push;
    assign word_o = st_q.word;

    // R2: a word needs sixteen more falls, so two pushes never abut
    p_one_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);

endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [WORD_W-1:0]          wdata_i,
    input  logic                       pop_i,
    output logic [WORD_W-1:0]          rdata_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       empty_o,
    output logic                       drop_o,
    output logic                       fill_o,
    output logic                       drain_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
    } fifo_t;

    fifo_t st_q, st_d;
    logic  full, empty, do_pop, do_push;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_TOP) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (st_q.cnt == CNT_TOP);
        empty   = (st_q.cnt == '0);
        do_pop  = pop_i & ~empty;
        // a pop at the same edge frees the slot a full FIFO needs
        do_push = push_i & (~full | do_pop);

        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata_i;
            st_d.wp           = ptr_step(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = ptr_step(st_q.rp);
        end
        unique case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase

        drop_o  = push_i & ~do_push;
        fill_o  = do_push & empty;
        drain_o = do_pop & ~do_push & (st_q.cnt == CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.mem[st_q.rp];
    assign count_o = st_q.cnt;
    assign empty_o = empty;

    // R4: occupancy is bounded by the depth
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_TOP);
    // R4: a word offered to a full FIFO without a pop leaves it full
    p_drop_keeps_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i) |=> (count_o == CNT_TOP));
    // R3: popping an empty FIFO changes nothing
    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_i && !push_i) |=> empty_o);

endmodule

// File: rtl/spi_rx_irq.sv
module spi_rx_irq
    import spi_rx_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int TO_BITS = 32,
    parameter int DIV_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fill_i,
    input  logic                       drain_i,
    input  logic                       drop_i,
    input  logic [$clog2(DEPTH+1)-1:0] count_i,
    input  logic [DIV_W-1:0]           div_i,
    input  logic [IRQ_N-1:0]           mask_i,
    input  logic [IRQ_N-1:0]           clr_i,
    output logic [IRQ_N-1:0]           raw_o,
    output logic [IRQ_N-1:0]           masked_o,
    output logic                       irq_o
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int BITS_W = $clog2(TO_BITS);
    localparam logic [BITS_W-1:0] BITS_TOP = BITS_W'(TO_BITS - 1);
    localparam logic [CNT_W-1:0]  HALF_LVL = CNT_W'(DEPTH / 2);

    typedef struct packed {
        logic              run;
        logic [DIV_W-1:0]  presc;
        logic [BITS_W-1:0] bits;
        logic              tmo;
        logic              ovr;
    } irq_t;

    irq_t st_q, st_d;
    logic fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;

        // bit-period timebase, started by the first word into an empty FIFO
        if (fill_i) begin
            st_d.run   = 1'b1;
            st_d.presc = '0;
            st_d.bits  = '0;
        end else if (st_q.run) begin
            if (st_q.presc == div_i) begin
                st_d.presc = '0;
                if (st_q.bits == BITS_TOP) begin
                    fire     = 1'b1;
                    st_d.run = 1'b0;
                end else begin
                    st_d.bits = st_q.bits + 1'b1;
                end
            end else begin
                st_d.presc = st_q.presc + 1'b1;
            end
        end
        if (drain_i) st_d.run = 1'b0;

        // emptying beats expiry; expiry beats a software clear
        if (drain_i)             st_d.tmo = 1'b0;
        else if (fire)           st_d.tmo = 1'b1;
        else if (clr_i[IRQ_TMO]) st_d.tmo = 1'b0;

        if (drop_i)              st_d.ovr = 1'b1;
        else if (clr_i[IRQ_OVR]) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        raw_o           = '0;
        raw_o[IRQ_HALF] = (count_i >= HALF_LVL);
        raw_o[IRQ_TMO]  = st_q.tmo;
        raw_o[IRQ_OVR]  = st_q.ovr;
    end

    for (genvar i = 0; i < IRQ_N; i++) begin : g_gate
        assign masked_o[i] = raw_o[i] & mask_i[i];
    end
    assign irq_o = |masked_o;

    // R6: expiry only ever comes out of a running count
    p_fire_from_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tmo) |-> $past(st_q.run));
    // R7: the pop that empties the FIFO leaves no timeout behind
    p_drain_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drain_i |=> !raw_o[IRQ_TMO]);
    // R8: a latched timeout and a live count never coexist
    p_no_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmo |-> !st_q.run);
    // R4: overrun stays until cleared
    p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o[IRQ_OVR] && !clr_i[IRQ_OVR]) |=> raw_o[IRQ_OVR]);
    // R9: the line needs at least one enabled source
    p_line_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_i != '0));

endmodule

// File: rtl/spi_slave_rx.sv
module spi_slave_rx
    import spi_rx_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int DEPTH   = 8,
    parameter int TO_BITS = 32,
    parameter int DIV_W   = 8,
    parameter int SYNC_N  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_i,
    input  logic                       cs_n_i,
    input  logic                       mosi_i,
    input  logic [DIV_W-1:0]           bit_div_i,
    input  logic                       rd_en_i,
    output logic [WORD_W-1:0]          rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0] rx_level_o,
    output logic                       rx_empty_o,
    input  logic [2:0]                 irq_mask_i,
    input  logic [2:0]                 irq_clr_i,
    output logic [2:0]                 irq_raw_o,
    output logic [2:0]                 irq_masked_o,
    output logic                       irq_o
);
    logic              word_push;
    logic [WORD_W-1:0] word_data;
    logic              fifo_drop, fifo_fill, fifo_drain;

    spi_rx_front #(
        .WORD_W (WORD_W),
        .SYNC_N (SYNC_N)
    ) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_i),
        .cs_n_i (cs_n_i),
        .mosi_i (mosi_i),
        .push_o (word_push),
        .word_o (word_data)
    );

    spi_rx_fifo #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (word_push),
        .wdata_i (word_data),
        .pop_i   (rd_en_i),
        .rdata_o (rd_data_o),
        .count_o (rx_level_o),
        .empty_o (rx_empty_o),
        .drop_o  (fifo_drop),
        .fill_o  (fifo_fill),
        .drain_o (fifo_drain)
    );

    spi_rx_irq #(
        .DEPTH   (DEPTH),
        .TO_BITS (TO_BITS),
        .DIV_W   (DIV_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_i   (fifo_fill),
        .drain_i  (fifo_drain),
        .drop_i   (fifo_drop),
        .count_i  (rx_level_o),
        .div_i    (bit_div_i),
        .mask_i   (irq_mask_i),
        .clr_i    (irq_clr_i),
        .raw_o    (irq_raw_o),
        .masked_o (irq_masked_o),
        .irq_o    (irq_o)
    );

endmodule

// File: tb/spi_slave_rx_tb.sv
module spi_slave_rx_tb;
    localparam int H     = 4;        // serial half period in clocks
    localparam int DEPTH = 8;
    localparam int WD    = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sclk, cs_n, mosi, rd_en;
    logic [7:0]  bit_div;
    logic [2:0]  irq_mask, irq_clr;
    logic [15:0] rd_data;
    logic [3:0]  rx_level;
    logic        rx_empty, irq;
    logic [2:0]  irq_raw, irq_masked;

    always #5 clk = ~clk;

    spi_slave_rx u_dut (
        .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .cs_n_i (cs_n),
        .mosi_i (mosi), .bit_div_i (bit_div), .rd_en_i (rd_en),
        .rd_data_o (rd_data), .rx_level_o (rx_level), .rx_empty_o (rx_empty),
        .irq_mask_i (irq_mask), .irq_clr_i (irq_clr), .irq_raw_o (irq_raw),
        .irq_masked_o (irq_masked), .irq_o (irq)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    bit live = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int          edge_n = 0;
    logic [15:0] mq[$];
    logic [15:0] pend_w[$];
    int          pend_t[$];
    int          last_due = 0;
    bit          m_run, m_tmo, m_ovr;
    int          fire_at;

    always @(posedge clk) begin
        edge_n = edge_n + 1;
        if (!rst_n) begin
            mq.delete(); m_run = 0; m_tmo = 0; m_ovr = 0;
        end else begin
            bit do_pop, do_push, fill, drain, drop, fire;
            logic [15:0] w;
            w       = '0;
            do_pop  = rd_en && mq.size() > 0;
            do_push = pend_t.size() > 0 && pend_t[0] == edge_n;
            if (do_push) begin
                w = pend_w.pop_front();
                void'(pend_t.pop_front());
            end
            fill  = do_push && mq.size() == 0;
            drain = do_pop && mq.size() == 1 && !do_push;
            drop  = do_push && mq.size() == DEPTH && !do_pop;
            if (do_pop) void'(mq.pop_front());
            if (do_push && !drop) mq.push_back(w);
            fire = 0;
            if (fill) begin
                m_run = 1; fire_at = edge_n + 32 * (int'(bit_div) + 1);
            end else if (m_run && edge_n == fire_at) begin
                fire = 1; m_run = 0;
            end
            if (drain) m_run = 0;
            if (drain) m_tmo = 0;
            else if (fire) m_tmo = 1;
            else if (irq_clr[1]) m_tmo = 0;
            if (drop) m_ovr = 1;
            else if (irq_clr[2]) m_ovr = 0;
        end
    end

    // compare every cycle, once inputs driven at the falling edge settle
    always @(negedge clk) begin
        #2;
        if (live && rst_n) begin
            logic [2:0] exp_raw;
            exp_raw = {m_ovr, m_tmo, mq.size() >= 4};
            check("R3 level", 32'(rx_level), mq.size());
            check("R3 empty", 32'(rx_empty), mq.size() == 0);
            if (mq.size() > 0) check("R1 head word", 32'(rd_data), 32'(mq[0]));
            check("R5 half-full raw", 32'(irq_raw[0]), 32'(exp_raw[0]));
            check("R6 timeout raw", 32'(irq_raw[1]), 32'(exp_raw[1]));
            check("R4 overrun raw", 32'(irq_raw[2]), 32'(exp_raw[2]));
            check("R9 masked", 32'(irq_masked), 32'(exp_raw & irq_mask));
            check("R9 line", 32'(irq), 32'(|(exp_raw & irq_mask)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic spi_frame(input logic [15:0] w, input int nbits);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
            if (i == 15) begin
                pend_w.push_back(w);
                pend_t.push_back(edge_n + 4);
                last_due = edge_n + 4;
            end
            repeat (H) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic pop1();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_clr(input logic [2:0] v);
        irq_clr = v;
        @(negedge clk);
        irq_clr = '0;
    endtask

    // ---------------- test sequence ----------------
    initial begin
        rst_n = 1'b0; sclk = 1'b1; cs_n = 1'b1; mosi = 1'b0; rd_en = 1'b0;
        bit_div = 8'd3; irq_mask = 3'b111; irq_clr = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        live = 1'b1;
        check("R10 reset empty", 32'(rx_empty), 1);
        check("R10 reset level", 32'(rx_level), 0);
        check("R10 reset raw", 32'(irq_raw), 0);
        check("R10 reset line", 32'(irq), 0);

        // R1, R6, R9: single word, timeout only enabled
        irq_mask = 3'b010;
        spi_frame(16'hA5C3, 16);
        while (edge_n < last_due + 32 * 4 + 1) @(negedge clk);
        check("R6 timeout fired", 32'(irq_raw[1]), 1);
        check("R1 word value", 32'(rd_data), 32'hA5C3);
        #2 check("R9 line on", 32'(irq), 1);
        @(negedge clk);
        irq_mask = 3'b000;
        #2 check("R9 line masked off", 32'(irq), 0);
        @(negedge clk);
        irq_mask = 3'b111;
        pop1();
        check("R7 drain clears timeout", 32'(irq_raw[1]), 0);

        // R7: drained before expiry, no timeout afterwards
        spi_frame(16'h1234, 16);
        repeat (40) @(negedge clk);
        pop1();
        repeat (200) @(negedge clk);
        check("R7 no late timeout", 32'(irq_raw[1]), 0);

        // R2: aborted frame and over-long frame
        spi_frame(16'hBEEF, 8);
        check("R2 partial discarded", 32'(rx_level), 0);
        spi_frame(16'h0F0F, 20);
        check("R2 one word per frame", 32'(rx_level), 1);
        check("R2 extra bits ignored", 32'(rd_data), 32'h0F0F);
        pop1();

        // R5: fill level, clear has no effect on it
        for (int k = 0; k < 5; k++) spi_frame(16'h3000 + 16'(k), 16);
        check("R5 half-full set", 32'(irq_raw[0]), 1);
        pulse_clr(3'b001);
        check("R5 clear ignored", 32'(irq_raw[0]), 1);
        pop1(); pop1();
        check("R5 half-full drops", 32'(irq_raw[0]), 0);
        pop1(); pop1(); pop1();
        check("R3 drained", 32'(rx_empty), 1);
        pop1();
        check("R3 pop on empty", 32'(rx_level), 0);

        // R4: overrun with a clear landing on the same edge
        for (int k = 0; k < 8; k++) spi_frame(16'hC000 + 16'(k * 3), 16);
        check("R4 full", 32'(rx_level), 8);
        last_due = 0;
        fork
            spi_frame(16'hDEAD, 16);
            begin
                wait (last_due != 0);
                while (edge_n != last_due - 1) @(negedge clk);
                irq_clr = 3'b100;
                @(negedge clk);
                irq_clr = '0;
            end
        join
        check("R4 overrun beats clear", 32'(irq_raw[2]), 1);
        check("R4 word dropped", 32'(rx_level), 8);
        pulse_clr(3'b100);
        check("R4 overrun cleared", 32'(irq_raw[2]), 0);
        check("R4 oldest kept", 32'(rd_data), 32'hC000);
        for (int k = 0; k < 8; k++) pop1();

        // R8: expiry and clear on the same edge, then no refire
        bit_div = 8'd0;
        spi_frame(16'h7E81, 16);
        while (edge_n != last_due + 31) @(negedge clk);
        irq_clr = 3'b010;
        @(negedge clk);
        irq_clr = '0;
        check("R8 expiry beats clear", 32'(irq_raw[1]), 1);
        pulse_clr(3'b010);
        check("R8 clear works", 32'(irq_raw[1]), 0);
        repeat (100) @(negedge clk);
        check("R8 no refire", 32'(irq_raw[1]), 0);
        pop1();
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule